// File: doc/BRIEF.md
# Window Watchdog Timer with Retained Bite Accounting

This block guards a running system against a stalled or runaway program. A two-stage prescaler divides the peripheral clock into a slow tick. A 6-bit down-counter steps on that tick. Software must refresh the counter inside an allowed window. A refresh that comes too soon, or no refresh before the counter runs out, raises a one-cycle system reset request. Once the timer has been armed by an activate strobe, the only ways to stop it are its own bite or a cold reset.

A small accounting unit beside the timer records every bite. It holds three things:
- a flag that reads all-ones after a watchdog reset;
- a saturating count of bites since power-on;
- the program-address input, captured in the cycle of the bite.

These registers are cleared only by the cold reset, so software can read them after the warm reset that the watchdog itself causes. A debug-freeze input stops the prescaler and the counter while a debugger halts the core.

With the default division of 4096 × 64 and a 32 MHz clock, one tick lasts about 8.2 ms. A full count of 64 ticks is therefore about 524 ms. The window opens after 48 ticks, about 393 ms, so a refresh every 450 ms keeps the system alive.

Top module: `wwdg_guard`

## Requirements
- R1: After cold reset the timer is inactive, `rst_req_o` is 0, `timer_o` reads the full value (all ones, 63 by default), and the bite flag, bite count and bite address are all zero.
- R2: While inactive, a refresh strobe has no effect: no reset request, the timer stays inactive and `timer_o` stays at full value.
- R3: An activate strobe while inactive arms the timer. It loads the full value and restarts the prescaler. `timer_o` then drops by one every DIV_LO × DIV_HI clock cycles, the first drop coming DIV_LO × DIV_HI cycles after the arming edge.
- R4: If never refreshed, `rst_req_o` goes high for exactly one cycle, 64 × DIV_LO × DIV_HI cycles after the arming edge. This is the cycle after the tick that finds the counter at zero.
- R5: A refresh while `timer_o` is at or below WIN_VAL (15 by default, that is, after at least 48 ticks) reloads the full value and restarts the prescaler, with no reset request. A refresh in the same cycle as the final tick still counts as in time.
- R6: A refresh while armed and `timer_o` is above WIN_VAL raises `rst_req_o` in the next cycle.
- R7: An activate strobe while armed has no effect. Once armed, the timer stays armed until it bites or a cold reset occurs.
- R8: While `dbg_freeze_i` is high, the prescaler and `timer_o` hold their values, so no expiry can occur.
- R9: On a bite, the timer returns to inactive with the full value loaded. `bitten_o` becomes all ones. `bite_addr_o` takes the value `pc_addr_i` had in the cycle before `rst_req_o` goes high.
- R10: The bite flag, count and address are changed by nothing but a bite or a cold reset. They survive bites and later activations, and a cold reset clears them.
- R11: `bite_cnt_o` rises by one per bite and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| cold_rst_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| activate_i | input | 1 | One-cycle strobe that arms the timer |
| refresh_i | input | 1 | One-cycle refresh strobe |
| dbg_freeze_i | input | 1 | Holds prescaler and counter while high |
| pc_addr_i | input | ADDR_W | Program address sampled on a bite |
| rst_req_o | output | 1 | One-cycle system reset request |
| active_o | output | 1 | Timer is armed |
| timer_o | output | T_W | Current down-counter value |
| bitten_o | output | FLAG_W | All ones after a watchdog reset, else zero |
| bite_cnt_o | output | BITE_W | Bites since cold reset, saturating |
| bite_addr_o | output | ADDR_W | Program address latched at the last bite |

## Verification
The assertions assume that `activate_i` and `refresh_i` are synchronous to `clk`. They also assume that `cold_rst_n` is held low across at least one rising edge, so that every register starts from a known value before any clocked property is evaluated.

The stimulus changes inputs only on falling edges. It applies reset for several cycles at the start and during the run. Random strobes are issued at low rates, with refreshes made more likely once `timer_o` has entered the window. This way the run reaches early bites, late bites and valid refreshes. Freeze is toggled rarely, so that long held stretches alternate with normal counting.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

   typedef enum logic {
      WD_IDLE = 1'b0,
      WD_RUN  = 1'b1
   } wd_state_e;

   localparam int unsigned WD_DEF_DIV_LO  = 4096;
   localparam int unsigned WD_DEF_DIV_HI  = 64;
   localparam int unsigned WD_DEF_T_W     = 6;
   localparam int unsigned WD_DEF_WIN_VAL = 15;

endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
   parameter int unsigned DIV_LO = 4096,
   parameter int unsigned DIV_HI = 64
) (
   input  logic clk,
   input  logic cold_rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);

   localparam int unsigned LO_W = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
   localparam int unsigned HI_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
   localparam logic [LO_W-1:0] LO_MAX = LO_W'(DIV_LO - 1);
   localparam logic [HI_W-1:0] HI_MAX = HI_W'(DIV_HI - 1);

   if (DIV_LO < 2) begin : g_chk_lo
      $error("wwdg_prescaler: DIV_LO must be at least 2");
   end
   if (DIV_HI < 1) begin : g_chk_hi
      $error("wwdg_prescaler: DIV_HI must be at least 1");
   end

   logic [LO_W-1:0] lo_q;
   logic            lo_wrap;

   assign lo_wrap = (lo_q == LO_MAX);

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         lo_q <= '0;
      end else if (clr) begin
         lo_q <= '0;
      end else if (en) begin
         lo_q <= lo_wrap ? '0 : lo_q + LO_W'(1);
      end
   end

   if (DIV_HI == 1) begin : g_single
      assign tick = en && lo_wrap;
   end else begin : g_cascade
      logic [HI_W-1:0] hi_q;
      logic            hi_wrap;

      assign hi_wrap = (hi_q == HI_MAX);
      assign tick    = en && lo_wrap && hi_wrap;

      always_ff @(posedge clk or negedge cold_rst_n) begin
         if (!cold_rst_n) begin
            hi_q <= '0;
         end else if (clr) begin
            hi_q <= '0;
         end else if (en && lo_wrap) begin
            hi_q <= hi_wrap ? '0 : hi_q + HI_W'(1);
         end
      end
   end

endmodule

// File: rtl/wwdg_timer.sv
module wwdg_timer
   import wwdg_pkg::*;
#(
   parameter int unsigned T_W     = 6,
   parameter int unsigned WIN_VAL = 15
) (
   input  logic           clk,
   input  logic           cold_rst_n,
   input  logic           activate,
   input  logic           refresh,
   input  logic           freeze,
   input  logic           tick,
   output logic           presc_en,
   output logic           presc_clr,
   output logic           bite,
   output logic           active,
   output logic [T_W-1:0] value,
   output logic           rst_req
);

   localparam logic [T_W-1:0] RELOAD = '1;
   localparam logic [T_W-1:0] WIN_L  = T_W'(WIN_VAL);

   if (T_W < 2) begin : g_chk_w
      $error("wwdg_timer: T_W must be at least 2");
   end
   if (WIN_VAL >= (2 ** T_W) - 1) begin : g_chk_win
      $error("wwdg_timer: WIN_VAL must be below the reload value");
   end

   wd_state_e      state_q;
   logic [T_W-1:0] cnt_q;
   logic           rst_req_q;
   logic           run;
   logic           early;
   logic           in_time;
   logic           expire;
   logic           arm;

   assign run     = (state_q == WD_RUN);
   assign early   = run && refresh && (cnt_q > WIN_L);
   assign in_time = run && refresh && !early;
   assign expire  = run && tick && (cnt_q == '0) && !in_time;
   assign arm     = !run && activate;

   assign bite      = early || expire;
   assign presc_en  = run && !freeze;
   assign presc_clr = arm || in_time || bite;

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         state_q   <= WD_IDLE;
         cnt_q     <= RELOAD;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= bite;
         if (bite) begin
            state_q <= WD_IDLE;
            cnt_q   <= RELOAD;
         end else if (arm || in_time) begin
            state_q <= WD_RUN;
            cnt_q   <= RELOAD;
         end else if (tick) begin
            cnt_q <= cnt_q - T_W'(1);
         end
      end
   end

   assign active  = run;
   assign value   = cnt_q;
   assign rst_req = rst_req_q;

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
      rst_req_q |=> !rst_req_q);

   assert_early_bites_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (run && refresh && (cnt_q > WIN_L)) |=> rst_req_q);

   assert_bite_idles_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      bite |=> (state_q == WD_IDLE && rst_req_q && cnt_q == RELOAD));

   assert_stays_on_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (run && !bite) |=> (state_q == WD_RUN));

   assert_stays_off_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (!run && !activate) |=> (state_q == WD_IDLE && !rst_req_q));

   assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (run && freeze && !refresh) |=> $stable(cnt_q));

endmodule

// File: rtl/wwdg_retain.sv
module wwdg_retain #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BITE_W = 16,
   parameter int unsigned FLAG_W = 32
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              bite,
   input  logic [ADDR_W-1:0] pc_addr,
   output logic [FLAG_W-1:0] flag,
   output logic [BITE_W-1:0] count,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [BITE_W-1:0] CNT_SAT = '1;

   if (BITE_W < 1 || ADDR_W < 1 || FLAG_W < 1) begin : g_chk_w
      $error("wwdg_retain: widths must be at least 1");
   end

   logic              flag_q;
   logic [BITE_W-1:0] count_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         flag_q  <= 1'b0;
         count_q <= '0;
         addr_q  <= '0;
      end else if (bite) begin
         flag_q <= 1'b1;
         addr_q <= pc_addr;
         if (count_q != CNT_SAT) begin
            count_q <= count_q + BITE_W'(1);
         end
      end
   end

   assign flag  = {FLAG_W{flag_q}};
   assign count = count_q;
   assign addr  = addr_q;

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      bite |=> (flag_q && addr_q == $past(pc_addr)));

   assert_retained_hold_R10: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !bite |=> ($stable(flag_q) && $stable(count_q) && $stable(addr_q)));

   assert_count_sat_R11: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (count_q == CNT_SAT) |=> (count_q == CNT_SAT));

endmodule

// File: rtl/wwdg_guard.sv
module wwdg_guard
   import wwdg_pkg::*;
#(
   parameter int unsigned DIV_LO  = WD_DEF_DIV_LO,
   parameter int unsigned DIV_HI  = WD_DEF_DIV_HI,
   parameter int unsigned T_W     = WD_DEF_T_W,
   parameter int unsigned WIN_VAL = WD_DEF_WIN_VAL,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned BITE_W  = 16,
   parameter int unsigned FLAG_W  = 32
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              activate_i,
   input  logic              refresh_i,
   input  logic              dbg_freeze_i,
   input  logic [ADDR_W-1:0] pc_addr_i,
   output logic              rst_req_o,
   output logic              active_o,
   output logic [T_W-1:0]    timer_o,
   output logic [FLAG_W-1:0] bitten_o,
   output logic [BITE_W-1:0] bite_cnt_o,
   output logic [ADDR_W-1:0] bite_addr_o
);

   logic tick;
   logic presc_en;
   logic presc_clr;
   logic bite;

   wwdg_prescaler #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI)
   ) presc_i (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .en         (presc_en),
      .clr        (presc_clr),
      .tick       (tick)
   );

   wwdg_timer #(
      .T_W     (T_W),
      .WIN_VAL (WIN_VAL)
   ) timer_i (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .activate   (activate_i),
      .refresh    (refresh_i),
      .freeze     (dbg_freeze_i),
      .tick       (tick),
      .presc_en   (presc_en),
      .presc_clr  (presc_clr),
      .bite       (bite),
      .active     (active_o),
      .value      (timer_o),
      .rst_req    (rst_req_o)
   );

   wwdg_retain #(
      .ADDR_W (ADDR_W),
      .BITE_W (BITE_W),
      .FLAG_W (FLAG_W)
   ) retain_i (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .bite       (bite),
      .pc_addr    (pc_addr_i),
      .flag       (bitten_o),
      .count      (bite_cnt_o),
      .addr       (bite_addr_o)
   );

endmodule

// File: tb/wwdg_guard_tb_top.sv
module wwdg_guard_tb_top;

   localparam int unsigned DLO = 4;
   localparam int unsigned DHI = 2;
   localparam int unsigned D   = DLO * DHI;
   localparam int unsigned TW  = 6;
   localparam int unsigned WIN = 15;
   localparam int unsigned AW  = 16;
   localparam int unsigned BW  = 3;
   localparam int unsigned FW  = 8;

   logic          clk = 1'b0;
   logic          cold_rst_n = 1'b0;
   logic          act = 1'b0;
   logic          rfr = 1'b0;
   logic          frz = 1'b0;
   logic [AW-1:0] pc = '0;

   logic          rst_req_o;
   logic          active_o;
   logic [TW-1:0] timer_o;
   logic [FW-1:0] bitten_o;
   logic [BW-1:0] bite_cnt_o;
   logic [AW-1:0] bite_addr_o;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   always #5 clk = ~clk;

   wwdg_guard #(
      .DIV_LO (DLO), .DIV_HI (DHI), .T_W (TW), .WIN_VAL (WIN),
      .ADDR_W (AW), .BITE_W (BW), .FLAG_W (FW)
   ) dut_i (
      .clk (clk), .cold_rst_n (cold_rst_n), .activate_i (act),
      .refresh_i (rfr), .dbg_freeze_i (frz), .pc_addr_i (pc),
      .rst_req_o (rst_req_o), .active_o (active_o), .timer_o (timer_o),
      .bitten_o (bitten_o), .bite_cnt_o (bite_cnt_o), .bite_addr_o (bite_addr_o)
   );

   // reference model built from the requirements
   logic          m_act, m_req, m_flag;
   logic [TW-1:0] m_cnt;
   int unsigned   m_ph;
   logic [BW-1:0] m_bites;
   logic [AW-1:0] m_addr;
   logic          m_tick, m_early, m_ok, m_exp, m_bite;

   always_comb begin
      m_tick  = m_act && !frz && (m_ph == D - 1);
      m_early = m_act && rfr && (m_cnt > TW'(WIN));
      m_ok    = m_act && rfr && !m_early;
      m_exp   = m_tick && (m_cnt == '0) && !m_ok;
      m_bite  = m_early || m_exp;
   end

   always @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         m_act <= 1'b0; m_req <= 1'b0; m_flag <= 1'b0; m_cnt <= '1;
         m_ph <= 0; m_bites <= '0; m_addr <= '0;
      end else begin
         m_req <= m_bite;
         if (m_bite) begin
            m_act <= 1'b0; m_cnt <= '1; m_ph <= 0;
            m_flag <= 1'b1; m_addr <= pc;
            if (m_bites != '1) m_bites <= m_bites + BW'(1);
         end else if ((!m_act && act) || m_ok) begin
            m_act <= 1'b1; m_cnt <= '1; m_ph <= 0;
         end else if (m_act && !frz) begin
            m_ph <= m_tick ? 0 : m_ph + 1;
            if (m_tick) m_cnt <= m_cnt - TW'(1);
         end
      end
   end

   task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cold_rst_n && cmp_en) begin
         check("R4 rst_req vs model", rst_req_o, m_req);
         check("R7 active vs model", active_o, m_act);
         check("R3 timer vs model", timer_o, m_cnt);
         check("R9 flag vs model", bitten_o, {FW{m_flag}});
         check("R11 count vs model", bite_cnt_o, m_bites);
         check("R9 address vs model", bite_addr_o, m_addr);
      end
   end

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic pulse_act();
      act = 1'b1; @(negedge clk); act = 1'b0;
   endtask

   task automatic pulse_rfr();
      rfr = 1'b1; @(negedge clk); rfr = 1'b0;
   endtask

   task automatic wait_val(input int v);
      int guard = 0;
      while (timer_o != TW'(v) && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic do_cold_reset();
      cold_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      cold_rst_n = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog: got hang expected completion");
      finish_sim();
   end

   initial begin
      int n;
      int seed_dummy;
      seed_dummy = $urandom(32'h0000_5eed);
      repeat (3) @(negedge clk);
      cold_rst_n = 1'b1;
      cmp_en = 1'b1;

      // R1 reset state
      check("R1 rst_req", rst_req_o, 0);
      check("R1 active", active_o, 0);
      check("R1 timer", timer_o, 63);
      check("R1 flag", bitten_o, 0);
      check("R1 count", bite_cnt_o, 0);
      check("R1 address", bite_addr_o, 0);

      // R2 refresh while idle ignored
      pulse_rfr();
      repeat (3) @(negedge clk);
      check("R2 no reset", rst_req_o, 0);
      check("R2 stays idle", active_o, 0);
      check("R2 timer full", timer_o, 63);
      check("R2 count untouched", bite_cnt_o, 0);

      // R3 and R4: arm, then let it expire
      pc = 16'h1234;
      pulse_act();
      check("R3 armed", active_o, 1);
      n = 0;
      while (!rst_req_o && n < 2000) begin
         @(negedge clk);
         n++;
         if (n == D - 1) check("R3 before first tick", timer_o, 63);
         if (n == D)     check("R3 after first tick", timer_o, 62);
      end
      check("R4 expiry cycle count", n, 64 * D);
      check("R9 idle after bite", active_o, 0);
      check("R9 timer reloaded", timer_o, 63);
      check("R9 flag all ones", bitten_o, 8'hFF);
      check("R11 count one", bite_cnt_o, 1);
      check("R9 address latched", bite_addr_o, 16'h1234);
      @(negedge clk);
      check("R4 single cycle", rst_req_o, 0);

      // R5 valid refresh in window
      pc = 16'hBEEF;
      pulse_act();
      wait_val(13);
      pulse_rfr();
      check("R5 no reset", rst_req_o, 0);
      check("R5 reload", timer_o, 63);
      repeat (20 * D) @(negedge clk);
      check("R5 still armed", active_o, 1);
      check("R5 count unchanged", bite_cnt_o, 1);

      // R7 activate while armed ignored
      wait_val(40);
      pulse_act();
      check("R7 no reload", (timer_o <= 40) ? 1 : 0, 1);
      check("R7 still armed", active_o, 1);

      // R8 freeze holds
      wait_val(30);
      frz = 1'b1;
      repeat (5 * D) @(negedge clk);
      check("R8 frozen value", timer_o, 30);
      check("R8 frozen armed", active_o, 1);
      frz = 1'b0;

      // R6 early refresh bites
      pc = 16'h0A0A;
      pulse_rfr();
      check("R6 early reset", rst_req_o, 1);
      check("R6 count", bite_cnt_o, 2);
      check("R6 address", bite_addr_o, 16'h0A0A);

      // window edges: 16 bites, 15 is accepted
      pulse_act();
      wait_val(16);
      pulse_rfr();
      check("R6 boundary value 16", rst_req_o, 1);
      check("R6 boundary count", bite_cnt_o, 3);
      pulse_act();
      wait_val(15);
      pulse_rfr();
      check("R5 boundary value 15", rst_req_o, 0);
      check("R5 boundary reload", timer_o, 63);

      // R11 saturation
      pulse_rfr();
      check("R6 bite from reloaded", bite_cnt_o, 4);
      for (int i = 0; i < 4; i++) begin
         pulse_act();
         pulse_rfr();
      end
      check("R11 saturated", bite_cnt_o, 7);

      // R10 retained through activation, cleared by cold reset
      pulse_act();
      repeat (2 * D) @(negedge clk);
      check("R10 flag kept", bitten_o, 8'hFF);
      check("R10 count kept", bite_cnt_o, 7);
      check("R10 address kept", bite_addr_o, 16'h0A0A);
      do_cold_reset();
      check("R10 flag cleared", bitten_o, 0);
      check("R10 count cleared", bite_cnt_o, 0);
      check("R10 address cleared", bite_addr_o, 0);
      check("R1 idle after cold reset", active_o, 0);

      // random phase, model compared every cycle
      for (int c = 0; c < 30000; c++) begin
         act = (($urandom % 100) < 2);
         if (timer_o <= TW'(WIN)) rfr = (($urandom % 100) < 4);
         else                     rfr = (($urandom % 1000) < 2);
         if (($urandom % 200) == 0) frz = ~frz;
         pc = AW'($urandom);
         @(negedge clk);
      end
      act = 1'b0; rfr = 1'b0; frz = 1'b0;
      @(negedge clk);
      finish_sim();
   end

endmodule